// File: doc/BRIEF.md
# Trigger Output Combiner

This block turns nine conditioned trigger inputs into six trigger outputs. Each output lane has its own selection logic with two terms. An OR term fires as soon as any of its chosen inputs pulses. An AND term fires once every one of its chosen inputs has pulsed, whether they pulsed together or in separate cycles. When either term fires, the lane launches an event into a programmable delay of 0 to 31 cycles. At the end of that delay the lane emits a single-cycle pulse.

The six lanes, in output order, are: the capture-buffer trigger, the gain-control packet-in trigger, and four debug pins numbered 0 to 3. Each lane is set up through a simple write port using two words. The selection word holds both input masks. The control word holds a hold-in-reset bit and the delay. Input conditioning and the mapping of lanes to physical pins lie outside this block.

Top module: `trg_out_combiner`

## Requirements
- R1: After reset every lane has both masks cleared and its hold bit set, and `trig_out` stays all zero whatever the inputs do.
- R2: A write with `cfg_we` high selects the lane with `cfg_addr[3:1]` and the word with `cfg_addr[0]` (0 = selection word, 1 = control word). Writes to lane indices 6 and 7 change no lane.
- R3: In the selection word, bit 16+i puts input i into the OR term and bit i puts input i into the AND term, for i = 0..8. All other bits are ignored.
- R4: In the control word, bit 31 holds the lane in reset and bits 4:0 give the delay. Bits 30:5 are ignored.
- R5: An input pulse on any OR-selected input produces an output pulse on that lane.
- R6: Each AND-selected input sets a sticky seen flag when it pulses. The AND term fires in the cycle where every selected input is either seen or pulsing now. All seen flags then clear, so a later lone input does not fire the lane.
- R7: A lane whose AND mask is zero never fires through its AND term, and with an OR mask of zero as well it never fires at all.
- R8: If an input that fires the lane is sampled at clock edge k, the output is high during the single cycle after edge k+D, where D (0..31) is the programmed delay.
- R9: Each rising edge of a lane's combined condition produces exactly one single-cycle output pulse, even if the input stays high for several cycles.
- R10: Setting the hold bit discards events already waiting in the delay line, clears the seen flags, and keeps the output low.
- R11: Lanes operate independently: one input pulse can fire several lanes, each with its own delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Lane index in bits 3:1, word select in bit 0 |
| cfg_wdata | input | 32 | Configuration write data |
| trig_in | input | 9 | Conditioned trigger input pulses |
| trig_out | output | 6 | Trigger output pulses, one per lane |

## Verification
The bench uses several kinds of input pulse to separate the different behaviours:
- Single-input pulses on OR-selected and unselected inputs separate mask decoding from the OR path.
- Staggered pulses on the AND-selected inputs, followed by a lone repeat pulse and then a simultaneous burst, show whether the seen flags accumulate and then clear.
- A held-high input separates edge-based pulsing from level following.
- All-ones bursts against zero masks, reserved-only data and out-of-range lane writes show that nothing fires spuriously.
- Delays of 0, 2, 7 and 31 cycles, and a hold applied while an event is in flight, confirm exact pulse placement and flushing of the delay line.

// File: rtl/trg_pkg.sv
package trg_pkg;

    localparam int N_IN     = 9;
    localparam int DLY_W    = 5;
    localparam int WORD_W   = 32;
    localparam int OR_LSB   = 16;
    localparam int AND_LSB  = 0;
    localparam int HOLD_BIT = 31;
    localparam int MAX_DLY  = (1 << DLY_W) - 1;

    typedef logic [N_IN-1:0] trg_vec_t;

    typedef struct packed {
        trg_vec_t or_sel;
        trg_vec_t and_sel;
    } sel_cfg_t;

    typedef struct packed {
        logic             hold;
        logic [DLY_W-1:0] dly;
    } lane_ctl_t;

    typedef enum logic {
        WSEL_MASK = 1'b0,
        WSEL_CTRL = 1'b1
    } wsel_e;

    localparam sel_cfg_t  SEL_RESET = '{or_sel: '0, and_sel: '0};
    localparam lane_ctl_t CTL_RESET = '{hold: 1'b1, dly: '0};

    function automatic sel_cfg_t word_to_sel(input logic [WORD_W-1:0] w);
        sel_cfg_t s;
        s.or_sel  = w[OR_LSB  +: N_IN];
        s.and_sel = w[AND_LSB +: N_IN];
        return s;
    endfunction

    function automatic lane_ctl_t word_to_ctl(input logic [WORD_W-1:0] w);
        lane_ctl_t c;
        c.hold = w[HOLD_BIT];
        c.dly  = w[DLY_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/trg_cfg_regs.sv
module trg_cfg_regs
    import trg_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int AW    = $clog2(N_OUT) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output sel_cfg_t            sel_o [N_OUT],
    output lane_ctl_t           ctl_o [N_OUT]
);
    localparam int IW = AW - 1;

    logic [IW-1:0] lane_idx;
    wsel_e         wsel;

    assign lane_idx = addr_i[AW-1:1];
    assign wsel     = wsel_e'(addr_i[0]);

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        logic hit;
        assign hit = we_i && (lane_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_o[g] <= SEL_RESET;
                ctl_o[g] <= CTL_RESET;
            end else if (hit) begin
                if (wsel == WSEL_MASK) sel_o[g] <= word_to_sel(wdata_i);
                else                   ctl_o[g] <= word_to_ctl(wdata_i);
            end
        end

        AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (ctl_o[g].hold && sel_o[g] == SEL_RESET)); // R1
    end

endmodule

// File: rtl/trg_combine.sv
module trg_combine
    import trg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trg_vec_t  trig_i,
    input  sel_cfg_t  sel_i,
    input  logic      hold_i,
    output logic      ev_o
);
    trg_vec_t seen_q;
    trg_vec_t have;
    logic     or_hit;
    logic     and_hit;
    logic     fire;
    logic     fire_q;
    logic     ev_q;

    assign have    = (seen_q | trig_i) & sel_i.and_sel;
    assign and_hit = (sel_i.and_sel != '0) && (have == sel_i.and_sel);
    assign or_hit  = |(trig_i & sel_i.or_sel);
    assign fire    = or_hit || and_hit;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            seen_q <= '0;
            fire_q <= 1'b0;
            ev_q   <= 1'b0;
        end else begin
            fire_q <= fire;
            ev_q   <= fire && !fire_q;
            seen_q <= and_hit ? '0 : (seen_q | (trig_i & sel_i.and_sel));
        end
    end

    assign ev_o = ev_q;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ev_q |=> !ev_q); // R9

    AST_EMPTY_AND: assert property (@(posedge clk) disable iff (rst)
        (sel_i.and_sel == '0 && (trig_i & sel_i.or_sel) == '0) |=> !ev_q); // R7

    AST_SEEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (and_hit || hold_i) |=> (seen_q == '0)); // R6

endmodule

// File: rtl/trg_delay.sv
module trg_delay
    import trg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_i,
    input  lane_ctl_t ctl_i,
    output logic      pulse_o
);
    logic [MAX_DLY-1:0] line_q;
    logic [DLY_W-1:0]   tap;

    assign tap = ctl_i.dly - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.hold) line_q <= '0;
        else                   line_q <= {line_q[MAX_DLY-2:0], ev_i};
    end

    assign pulse_o = (ctl_i.dly == '0) ? ev_i : line_q[tap];

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.hold && $past(ctl_i.hold)) |-> !pulse_o); // R10

endmodule

// File: rtl/trg_out_combiner.sv
module trg_out_combiner
    import trg_pkg::*;
#(
    parameter int N_OUT = 6,
    localparam int AW   = $clog2(N_OUT) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   trig_in,
    output logic [N_OUT-1:0]  trig_out
);
    sel_cfg_t  sel [N_OUT];
    lane_ctl_t ctl [N_OUT];

    trg_cfg_regs #(.N_OUT(N_OUT), .AW(AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .sel_o   (sel),
        .ctl_o   (ctl)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        logic ev;

        trg_combine u_comb (
            .clk    (clk),
            .rst    (rst),
            .trig_i (trig_in),
            .sel_i  (sel[g]),
            .hold_i (ctl[g].hold),
            .ev_o   (ev)
        );

        trg_delay u_dly (
            .clk     (clk),
            .rst     (rst),
            .ev_i    (ev),
            .ctl_i   (ctl[g]),
            .pulse_o (trig_out[g])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (trig_out == '0)); // R1

endmodule

// File: tb/sim_trg_out_combiner.sv
module sim_trg_out_combiner;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_OUT = 6;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [8:0]       trig_in = '0;
    logic [N_OUT-1:0] trig_out;

    trg_out_combiner #(.N_OUT(N_OUT)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .trig_in   (trig_in),
        .trig_out  (trig_out)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    lane;
        string req;
    } exp_t;

    exp_t  sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Driver side: every task starts and ends at a falling edge.
    task automatic wr(input int lane, input bit ctrl_word, input logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(lane * 2 + (ctrl_word ? 1 : 0));
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic expect_out(input int lane, input int dly, input string req);
        exp_t e;
        e.at   = cyc + 1 + dly;
        e.lane = lane;
        e.req  = req;
        sbq.push_back(e);
    endtask

    task automatic fire_in(input logic [8:0] v, input int len);
        trig_in = v;
        repeat (len) @(negedge clk);
        trig_in = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: one comparison of the whole output vector per cycle.
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [N_OUT-1:0] exp_v;
            string            why;
            exp_v = '0;
            why   = cur_req;
            for (int k = sbq.size() - 1; k >= 0; k--) begin
                if (sbq[k].at <= cyc) begin
                    if (sbq[k].at == cyc) exp_v[sbq[k].lane] = 1'b1;
                    why = sbq[k].req;
                    sbq.delete(k);
                end
            end
            checks++;
            if (trig_out !== exp_v) begin
                errors++;
                $display("FAIL %s cycle %0d: trig_out actual %b expected %b",
                         why, cyc, trig_out, exp_v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL %s watchdog: actual running expected finished", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset even with all inputs high
        repeat (3) @(negedge clk);
        trig_in = '1;
        @(negedge clk);
        checks++;
        if (trig_out !== '0) begin
            errors++;
            $display("FAIL R1 in reset: trig_out actual %b expected %b", trig_out, 6'b0);
        end
        trig_in = '0;
        rst = 1'b0;
        idle(2);

        // R1: after reset every lane held, zero masks, nothing fires
        cur_req = "R1";
        fire_in('1, 1);
        idle(40);

        // R2: lane indices 6 and 7 are not aliased onto real lanes
        cur_req = "R2";
        wr(6, 0, 32'h01FF_01FF);
        wr(6, 1, 32'h0000_0000);
        wr(7, 0, 32'h01FF_01FF);
        wr(7, 1, 32'h0000_0000);
        fire_in('1, 1);
        idle(40);

        // R5 / R3: lane 0 OR-selects input 3 (bit 19), delay 0
        cur_req = "R5";
        wr(0, 0, 32'h0008_0000);
        wr(0, 1, 32'h0000_0000);
        expect_out(0, 0, "R5");
        fire_in(9'h008, 1);
        idle(3);
        fire_in(9'h004, 1);
        idle(3);
        wr(0, 1, 32'h8000_0000);

        // R8 / R4 / R3: lane 1 OR-selects inputs 8 and 0, delay 7
        cur_req = "R8";
        wr(1, 0, 32'h0101_0000);
        wr(1, 1, 32'h0000_0007);
        expect_out(1, 7, "R4");
        fire_in(9'h100, 1);
        idle(12);
        expect_out(1, 7, "R8");
        fire_in(9'h001, 1);
        idle(12);
        wr(1, 1, 32'h8000_0000);

        // R6 / R3: lane 2 AND-selects inputs 1, 4, 6, delay 3
        cur_req = "R6";
        wr(2, 0, 32'h0000_0052);
        wr(2, 1, 32'h0000_0003);
        fire_in(9'h002, 1);
        idle(2);
        fire_in(9'h010, 1);
        idle(4);
        expect_out(2, 3, "R6");
        fire_in(9'h040, 1);
        idle(8);
        fire_in(9'h040, 1);       // lone repeat, flags were cleared
        idle(8);
        fire_in(9'h002, 1);       // seen 1 and 6 now, still no fire
        idle(3);
        expect_out(2, 3, "R6");
        fire_in(9'h052, 1);
        idle(8);

        // R10: hold clears the seen flags of lane 2
        cur_req = "R10";
        fire_in(9'h002, 1);
        fire_in(9'h010, 1);
        wr(2, 1, 32'h8000_0003);
        wr(2, 1, 32'h0000_0003);
        fire_in(9'h040, 1);
        idle(8);
        wr(2, 1, 32'h8000_0000);

        // R7 / R3 / R4: reserved-only data, zero masks, hold cleared
        cur_req = "R7";
        wr(3, 0, 32'hFE00_FE00);
        wr(3, 1, 32'h7FFF_FFE0);
        fire_in('1, 1);
        idle(5);
        fire_in('1, 3);
        idle(5);
        wr(3, 1, 32'h8000_0000);

        // R8: lane 4 at the largest delay, OR-selects input 5
        cur_req = "R8";
        wr(4, 0, 32'h0020_0000);
        wr(4, 1, 32'h0000_001F);
        expect_out(4, 31, "R8");
        fire_in(9'h020, 1);
        idle(36);

        // R10: event in flight is discarded by a hold
        cur_req = "R10";
        fire_in(9'h020, 1);
        idle(10);
        wr(4, 1, 32'h8000_001F);
        wr(4, 1, 32'h0000_001F);
        idle(30);
        wr(4, 1, 32'h8000_0000);

        // R9: lane 5 OR-selects input 7, delay 2, input held 6 cycles
        cur_req = "R9";
        wr(5, 0, 32'h0080_0000);
        wr(5, 1, 32'h0000_0002);
        expect_out(5, 2, "R9");
        fire_in(9'h080, 6);
        idle(8);

        // R11: lanes 0 and 5 fire from one stimulus with their own delays
        cur_req = "R11";
        wr(0, 0, 32'h0004_0000);
        wr(0, 1, 32'h0000_0001);
        expect_out(0, 1, "R11");
        expect_out(5, 2, "R11");
        fire_in(9'h084, 1);
        idle(8);

        idle(40);
        done = 1'b1;
        if (sbq.size() != 0) begin
            foreach (sbq[k]) begin
                checks++;
                errors++;
                $display("FAIL %s lane %0d: pulse actual missing expected at cycle %0d",
                         sbq[k].req, sbq[k].lane, sbq[k].at);
            end
        end
        summary();
        $finish;
    end

endmodule